// File: doc/BRIEF.md
# EDO DRAM Cycle-Type Decoder

This block is the device-side control front end of an extended-data-out DRAM. A clock much faster than the memory strobes samples them. The block watches the row strobe, two byte-lane column strobes, write enable and output enable. It names the kind of every row-strobe cycle and reports the class when the row strobe rises. It also keeps the internal refresh row counter, issues one-clock write pulses per byte lane, and produces the per-lane output-drive enables that a data pad ring would use.

The column-strobe mode is taken from the OR of the lane strobes. It begins when the first lane goes low and ends when the last lane returns high. Lane writes and lane output release still follow each strobe on its own. All strobes are active low. Every output is registered, so an output reflects the strobe sample taken at the same clock edge. The storage array is not part of the block; a test environment attaches its own.

Top module: `edram_cycle_decoder`

## Requirements
- R1: If any lane strobe is low in the sample where the row strobe falls, the cycle is a counter refresh. On the next output update, row_o shows the current counter value and the counter advances by one. When the row strobe rises, cls_o reports 6.
- R2: If no lane strobe goes low during the whole row-strobe-low period, row_o takes addr at the row fall. At the row rise, cls_vld_o and ref_vld_o pulse for one clock with cls_o = 5. Class codes are: 0 idle, 1 read, 2 early write, 3 delayed write, 4 read-modify-write, 5 row-only refresh, 6 counter refresh, 7 hidden refresh, 8 self refresh. ref_vld_o pulses for codes 5 to 8.
- R3: If we_n is low in the sample where the first lane strobe falls, the cycle is an early write (code 2). wr_o pulses for each low lane in that sample, and dq_oe_o stays 0 for the whole cycle.
- R4: If we_n falls while a read-mode column cycle is active and oe_n has not been low since the strobe fell, the cycle is a delayed write (code 3). wr_o pulses for each low lane in the sample of the we_n fall.
- R5: If oe_n has been sampled low in a read-mode column cycle before we_n falls, the cycle is a read-modify-write (code 4). It gets the same write pulse as R4, and output drive ends once the write begins.
- R6: col_o captures addr when the first lane strobe falls. A lane's wr_o bit is set only in a sample where that lane's own strobe is low. The cycle class comes from the first column cycle of the row-strobe cycle.
- R7: In a read, dq_oe_o[i] is 1 while oe_n is low and lane i has been strobed. It stays 1 after a lane strobe or the row strobe rises alone. It clears only in a sample where both the row strobe and that lane strobe are high.
- R8: If a lane strobe is still low from a read when the row strobe falls again, the cycle is a hidden refresh (code 7). It steps the counter as in R1, and the read data stays driven.
- R9: The refresh counter is REF_W bits wide (default 12), so it wraps from 4095 to 0.
- R10: A counter refresh whose row strobe stays low for at least SELF_CYC samples (default 32, counting the fall sample) is reported as self refresh (code 8).
- R11: When a second lane strobe falls later in a column cycle and the we_n level disagrees with that cycle's mode, err_o pulses for one clock and that lane gets no write pulse.
- R12: After reset, every output is 0 and the refresh counter starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Lane column strobes, bit 0 low byte, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| cls_o | output | 4 | Class of the last finished row-strobe cycle |
| cls_vld_o | output | 1 | One-clock pulse when cls_o is updated |
| ref_vld_o | output | 1 | One-clock pulse when the finished cycle was a refresh |
| row_o | output | ROW_W | Row opened (address or counter value) |
| col_o | output | ROW_W | Column captured at first lane strobe fall |
| wr_o | output | LANES | One-clock write pulse per lane |
| dq_oe_o | output | LANES | Per-lane output drive enable |
| err_o | output | 1 | One-clock pulse on a lane mode mismatch |

## Verification
A wrong internal mode or class shows up at the ports no later than the next row-strobe rise, as a wrong cls_o. A wrong write-mode bit shows up one clock after the strobe edge, as a stray or missing wr_o pulse or a dq_oe_o that turns on during a write. A lost or doubled counter step changes row_o at the very next counter refresh and shifts every later one, so the wrap point lands on the wrong cycle. The most likely slip in the hidden-refresh path is a drive latch cleared by a single strobe rise. It shows as dq_oe_o dropping one clock after the row strobe rises while a lane is still held low.

// File: rtl/edram_cls_pkg.sv
package edram_cls_pkg;
  typedef enum logic [3:0] {
    CY_IDLE = 4'd0,
    CY_READ = 4'd1,
    CY_EWR  = 4'd2,
    CY_DWR  = 4'd3,
    CY_RMW  = 4'd4,
    CY_ROR  = 4'd5,
    CY_CBR  = 4'd6,
    CY_HID  = 4'd7,
    CY_SELF = 4'd8
  } cyc_e;

  // cycle that opened a row from the pins (refresh-only until a column strobe arrives)
  function automatic logic is_access(cyc_e c);
    return c inside {CY_ROR, CY_READ, CY_EWR, CY_DWR, CY_RMW};
  endfunction

  function automatic logic is_refresh(cyc_e c);
    return c inside {CY_ROR, CY_CBR, CY_HID, CY_SELF};
  endfunction

  // a long counter refresh becomes self refresh at the end of the cycle
  function automatic cyc_e final_class(cyc_e c, logic long_low);
    return (c == CY_CBR && long_low) ? CY_SELF : c;
  endfunction
endpackage

// File: rtl/edram_strobe_reg.sv
module edram_strobe_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] prev_o
);
  // active-low strobes idle high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= '1;
    else        prev_o <= sig_i;
  end
endmodule

// File: rtl/edram_ref_ctr.sv
module edram_ref_ctr #(
  parameter int REF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  output logic [REF_W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (step_i) cnt_o <= cnt_o + REF_W'(1);
  end
endmodule

// File: rtl/edram_lane_out.sv
module edram_lane_out #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] set_i,
  input  logic [LANES-1:0] clr_i,
  input  logic             oe_gate_i,
  output logic [LANES-1:0] hold_o,
  output logic [LANES-1:0] dq_oe_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hold_d;
    always_comb begin
      if (set_i[g])      hold_d = 1'b1;
      else if (clr_i[g]) hold_d = 1'b0;
      else               hold_d = hold_o[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_o[g]  <= 1'b0;
        dq_oe_o[g] <= 1'b0;
      end else begin
        hold_o[g]  <= hold_d;
        dq_oe_o[g] <= hold_d & oe_gate_i;
      end
    end
  end
endmodule

// File: rtl/edram_cycle_decoder.sv
module edram_cycle_decoder
  import edram_cls_pkg::*;
#(
  parameter int ROW_W    = 13,
  parameter int REF_W    = 12,
  parameter int LANES    = 2,
  parameter int SELF_CYC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic [LANES-1:0] cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  output logic [3:0]       cls_o,
  output logic             cls_vld_o,
  output logic             ref_vld_o,
  output logic [ROW_W-1:0] row_o,
  output logic [ROW_W-1:0] col_o,
  output logic [LANES-1:0] wr_o,
  output logic [LANES-1:0] dq_oe_o,
  output logic             err_o
);
  localparam int RC_W = $clog2(SELF_CYC + 1);
  localparam int NS   = LANES + 2;

  // sampled strobe history
  logic [NS-1:0] smp, prv;
  assign smp = {ras_n, we_n, cas_n};
  edram_strobe_reg #(.N(NS)) u_prev (.clk(clk), .rst_n(rst_n), .sig_i(smp), .prev_o(prv));

  // named events
  logic             prev_ras, prev_we, ras_fall, ras_rise, ras_held;
  logic             cas_now, cas_prev, cas_on, cas_off, we_fall, cbr_start;
  logic [LANES-1:0] lane_fall;
  assign prev_ras  = prv[NS-1];
  assign prev_we   = prv[LANES];
  assign ras_fall  = prev_ras & ~ras_n;
  assign ras_rise  = ~prev_ras & ras_n;
  assign ras_held  = ~prev_ras & ~ras_n;
  assign cas_now   = ~&cas_n;
  assign cas_prev  = ~&prv[LANES-1:0];
  assign cas_on    = cas_now & ~cas_prev;
  assign cas_off   = ~cas_now & cas_prev;
  assign we_fall   = prev_we & ~we_n;
  assign lane_fall = prv[LANES-1:0] & ~cas_n;
  assign cbr_start = ras_fall & cas_now;

  logic [REF_W-1:0] ref_cnt;
  edram_ref_ctr #(.REF_W(REF_W)) u_ctr (.clk(clk), .rst_n(rst_n), .step_i(cbr_start), .cnt_o(ref_cnt));

  // cycle state
  cyc_e             cls_q, cls_d, clso_q, clso_d;
  logic             mode_wr_q, mode_wr_d, rd_seen_q, rd_seen_d, first_q, first_d;
  logic             vld_d, refv_d, err_d;
  logic [RC_W-1:0]  rcnt_q, rcnt_d;
  logic [ROW_W-1:0] row_d, col_d;
  logic [LANES-1:0] wr_d, hold;

  always_comb begin
    cls_d = cls_q;  clso_d = clso_q;  mode_wr_d = mode_wr_q;
    rd_seen_d = rd_seen_q;  first_d = first_q;  rcnt_d = rcnt_q;
    row_d = row_o;  col_d = col_o;  wr_d = '0;
    vld_d = 1'b0;  refv_d = 1'b0;  err_d = 1'b0;
    if (ras_fall) begin
      first_d = 1'b1;
      rcnt_d  = RC_W'(1);
      if (cas_now) begin
        row_d = ROW_W'(ref_cnt);
        cls_d = (|hold) ? CY_HID : CY_CBR;
      end else begin
        row_d = addr;
        cls_d = CY_ROR;
      end
    end else if (ras_rise) begin
      vld_d  = 1'b1;
      clso_d = final_class(cls_q, rcnt_q == RC_W'(SELF_CYC));
      refv_d = is_refresh(clso_d);
      cls_d  = CY_IDLE;
    end else if (ras_held) begin
      if (rcnt_q != RC_W'(SELF_CYC)) rcnt_d = rcnt_q + RC_W'(1);
      if (is_access(cls_q)) begin
        if (cas_on) begin
          mode_wr_d = ~we_n;
          col_d     = addr;
          rd_seen_d = we_n & ~oe_n;
          wr_d      = ~cas_n & {LANES{~we_n}};
          if (cls_q == CY_ROR) cls_d = we_n ? CY_READ : CY_EWR;
        end else if (cas_now) begin
          for (int i = 0; i < LANES; i++) begin
            if (lane_fall[i]) begin
              if (~we_n == mode_wr_q) wr_d[i] = mode_wr_q;
              else                    err_d   = 1'b1;
            end
          end
          if (we_fall && !mode_wr_q) begin
            wr_d      = ~cas_n;
            mode_wr_d = 1'b1;
            if (first_q && cls_q == CY_READ) cls_d = rd_seen_q ? CY_RMW : CY_DWR;
          end
          if (!mode_wr_q && !oe_n) rd_seen_d = 1'b1;
        end
        if (cas_off) first_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q <= CY_IDLE;  clso_q <= CY_IDLE;  mode_wr_q <= 1'b0;
      rd_seen_q <= 1'b0;  first_q <= 1'b0;  rcnt_q <= '0;
      row_o <= '0;  col_o <= '0;  wr_o <= '0;
      cls_vld_o <= 1'b0;  ref_vld_o <= 1'b0;  err_o <= 1'b0;
    end else begin
      cls_q <= cls_d;  clso_q <= clso_d;  mode_wr_q <= mode_wr_d;
      rd_seen_q <= rd_seen_d;  first_q <= first_d;  rcnt_q <= rcnt_d;
      row_o <= row_d;  col_o <= col_d;  wr_o <= wr_d;
      cls_vld_o <= vld_d;  ref_vld_o <= refv_d;  err_o <= err_d;
    end
  end
  assign cls_o = clso_q;

  // per-lane read data drive, released at the later of row and lane strobe rise
  logic [LANES-1:0] lane_set, lane_clr;
  assign lane_set = {LANES{ras_held & is_access(cls_d) & cas_now & ~mode_wr_d}} & ~cas_n;
  assign lane_clr = cas_n & {LANES{ras_n}};
  edram_lane_out #(.LANES(LANES)) u_lane (
    .clk(clk), .rst_n(rst_n), .set_i(lane_set), .clr_i(lane_clr),
    .oe_gate_i(~oe_n & ~mode_wr_d), .hold_o(hold), .dq_oe_o(dq_oe_o)
  );
endmodule

// File: rtl/edram_cycle_decoder_chk.sv
module edram_cycle_decoder_chk #(
  parameter int LANES = 2,
  parameter int REF_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic [LANES-1:0] cas_n,
  input logic             oe_n,
  input logic [3:0]       cls_o,
  input logic             cls_vld_o,
  input logic [LANES-1:0] wr_o,
  input logic [LANES-1:0] dq_oe_o,
  input logic             cbr_start,
  input logic [REF_W-1:0] ref_cnt,
  input logic             mode_wr_q
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cbr_start |=> ref_cnt == $past(ref_cnt) + REF_W'(1)); // R9
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cbr_start |=> $stable(ref_cnt)); // R1
  AST_VLD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    cls_vld_o |-> $past(ras_n) && !$past(ras_n, 2)); // R2
  AST_CLS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cls_vld_o |-> cls_o != 4'd0 && cls_o <= 4'd8); // R2
  AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (|dq_oe_o) |-> !$past(oe_n)); // R7
  AST_QUIET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_q |-> dq_oe_o == '0); // R3
  for (genvar g = 0; g < LANES; g++) begin : g_ln
    AST_WR_OWN_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o[g] |-> !$past(cas_n[g])); // R6
    AST_HIZ_LATER: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe_o[g] |-> !($past(cas_n[g]) && $past(ras_n))); // R7
  end
endmodule

bind edram_cycle_decoder edram_cycle_decoder_chk #(.LANES(LANES), .REF_W(REF_W)) u_chk (.*);

// File: tb/edram_cycle_decoder_tb.sv
module edram_cycle_decoder_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ras_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0]  cas_n = 2'b11;
  logic [12:0] addr = '0;
  logic [3:0]  cls_o;
  logic        cls_vld_o, ref_vld_o, err_o;
  logic [12:0] row_o, col_o;
  logic [1:0]  wr_o, dq_oe_o;

  always #2 clk = ~clk;

  edram_cycle_decoder u_dut (.clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .cls_o(cls_o), .cls_vld_o(cls_vld_o), .ref_vld_o(ref_vld_o),
    .row_o(row_o), .col_o(col_o), .wr_o(wr_o), .dq_oe_o(dq_oe_o), .err_o(err_o));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_cls, m_row, m_col, m_cnt, m_rcnt;
  bit m_mode, m_rd, m_first, m_pr, m_pw;
  bit [1:0] m_pc, mh;
  int e_cls; bit e_vld, e_ref, e_err; bit [1:0] e_wr, e_oe;

  function automatic string tag_of(int c);
    case (c)
      1: return "R7"; 2: return "R3"; 3: return "R4"; 4: return "R5";
      5: return "R2"; 6: return "R1"; 7: return "R8"; 8: return "R10";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cls = 0; m_row = 0; m_col = 0; m_cnt = 0; m_rcnt = 0;
      m_mode = 0; m_rd = 0; m_first = 0; m_pr = 1; m_pw = 1; m_pc = 2'b11; mh = 0;
      e_cls = 0; e_vld = 0; e_ref = 0; e_err = 0; e_wr = 0; e_oe = 0;
    end else begin
      bit rf, rr, rh, cn, cp;
      int ocls; bit omode, ord; bit [1:0] oh;
      rf = m_pr && !ras_n; rr = !m_pr && ras_n; rh = !m_pr && !ras_n;
      cn = (cas_n != 2'b11); cp = (m_pc != 2'b11);
      ocls = m_cls; omode = m_mode; ord = m_rd; oh = mh;
      e_vld = 0; e_ref = 0; e_wr = 0; e_err = 0;
      if (rf) begin
        m_first = 1; m_rcnt = 1;
        if (cn) begin m_row = m_cnt; m_cnt = (m_cnt + 1) % 4096; m_cls = (oh != 0) ? 7 : 6; end
        else begin m_row = addr; m_cls = 5; end
      end else if (rr) begin
        e_vld = 1; e_cls = (ocls == 6 && m_rcnt >= 32) ? 8 : ocls; e_ref = (e_cls >= 5); m_cls = 0;
      end else if (rh) begin
        if (m_rcnt < 32) m_rcnt++;
        if (ocls >= 1 && ocls <= 5) begin
          if (cn && !cp) begin
            m_mode = !we_n; m_col = addr; m_rd = we_n && !oe_n;
            e_wr = we_n ? 2'b00 : ~cas_n;
            if (ocls == 5) m_cls = we_n ? 1 : 2;
          end else if (cn) begin
            for (int i = 0; i < 2; i++)
              if (m_pc[i] && !cas_n[i]) begin
                if ((!we_n) == omode) begin if (omode) e_wr[i] = 1; end
                else e_err = 1;
              end
            if (m_pw && !we_n && !omode) begin
              e_wr = ~cas_n; m_mode = 1;
              if (m_first && ocls == 1) m_cls = ord ? 4 : 3;
            end
            if (!omode && !oe_n) m_rd = 1;
          end
          if (!cn && cp) m_first = 0;
        end
      end
      for (int i = 0; i < 2; i++) begin
        if (rh && m_cls >= 1 && m_cls <= 5 && cn && !m_mode && !cas_n[i]) mh[i] = 1;
        else if (cas_n[i] && ras_n) mh[i] = 0;
        e_oe[i] = mh[i] && !oe_n && !m_mode;
      end
      m_pr = ras_n; m_pw = we_n; m_pc = cas_n;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(cls_o, e_cls, tag_of(e_cls));
    chk(cls_vld_o, e_vld, "R2");
    chk(ref_vld_o, e_ref, "R1");
    chk(row_o, m_row, "R1/R2");
    chk(col_o, m_col, "R6");
    chk(wr_o, e_wr, "R6");
    chk(dq_oe_o, e_oe, "R7");
    chk(err_o, e_err, "R11");
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input bit r, input bit [1:0] c, input bit w, input bit o, input int a);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = 13'(a);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12: reset state
    chk(cls_o, 0, "R12"); chk(row_o, 0, "R12"); chk(dq_oe_o, 0, "R12"); chk(wr_o, 0, "R12");

    // R2: row-only refresh
    cyc(0, 2'b11, 1, 1, 13'h1ABC); chk(row_o, 13'h1ABC, "R2");
    repeat (3) cyc(0, 2'b11, 1, 1, 0);
    cyc(1, 2'b11, 1, 1, 0); chk(cls_o, 5, "R2"); chk(ref_vld_o, 1, "R2");

    // R1: counter refresh, both lanes then lower lane only
    cyc(1, 2'b00, 1, 1, 0); cyc(0, 2'b00, 1, 1, 0); chk(row_o, 0, "R1");
    cyc(0, 2'b00, 1, 1, 0); cyc(1, 2'b00, 1, 1, 0); chk(cls_o, 6, "R1");
    cyc(1, 2'b11, 1, 1, 0); cyc(1, 2'b10, 1, 1, 0); cyc(0, 2'b10, 1, 1, 0); chk(row_o, 1, "R1");
    cyc(1, 2'b10, 1, 1, 0); chk(cls_o, 6, "R1"); cyc(1, 2'b11, 1, 1, 0);

    // R7: read, drive held past row strobe rise
    cyc(0, 2'b11, 1, 1, 40); cyc(0, 2'b00, 1, 0, 5); chk(dq_oe_o, 3, "R7"); chk(col_o, 5, "R6");
    cyc(0, 2'b00, 1, 0, 0); cyc(1, 2'b00, 1, 0, 0); chk(cls_o, 1, "R7"); chk(dq_oe_o, 3, "R7");
    cyc(1, 2'b11, 1, 0, 0); chk(dq_oe_o, 0, "R7");

    // R3: early write, outputs quiet though OE is low
    cyc(1, 2'b11, 0, 0, 0); cyc(0, 2'b11, 0, 0, 41); cyc(0, 2'b00, 0, 0, 9);
    chk(wr_o, 3, "R3"); chk(dq_oe_o, 0, "R3");
    cyc(0, 2'b00, 0, 0, 0); chk(wr_o, 0, "R3");
    cyc(1, 2'b11, 1, 1, 0); chk(cls_o, 2, "R3");

    // R6: lower lane only
    cyc(1, 2'b11, 0, 1, 0); cyc(0, 2'b11, 0, 1, 42); cyc(0, 2'b10, 0, 1, 7); chk(wr_o, 1, "R6");
    cyc(1, 2'b11, 1, 1, 0);

    // R4: delayed write
    cyc(0, 2'b11, 1, 1, 43); cyc(0, 2'b00, 1, 1, 3); cyc(0, 2'b00, 1, 1, 0);
    cyc(0, 2'b00, 0, 1, 0); chk(wr_o, 3, "R4");
    cyc(0, 2'b00, 0, 1, 0); cyc(1, 2'b11, 1, 1, 0); chk(cls_o, 3, "R4");

    // R5: read-modify-write
    cyc(0, 2'b11, 1, 1, 44); cyc(0, 2'b00, 1, 0, 4); chk(dq_oe_o, 3, "R5");
    cyc(0, 2'b00, 1, 0, 0); cyc(0, 2'b00, 1, 1, 0); chk(dq_oe_o, 0, "R5");
    cyc(0, 2'b00, 0, 1, 0); chk(wr_o, 3, "R5");
    cyc(1, 2'b11, 1, 1, 0); chk(cls_o, 4, "R5");

    // R8: hidden refresh
    cyc(0, 2'b11, 1, 1, 45); cyc(0, 2'b00, 1, 0, 6); cyc(0, 2'b00, 1, 0, 0);
    cyc(1, 2'b00, 1, 0, 0); cyc(1, 2'b00, 1, 0, 0);
    cyc(0, 2'b00, 1, 0, 0); chk(row_o, 2, "R8"); chk(dq_oe_o, 3, "R8");
    cyc(0, 2'b00, 1, 0, 0); cyc(1, 2'b00, 1, 0, 0); chk(cls_o, 7, "R8"); chk(dq_oe_o, 3, "R8");
    cyc(1, 2'b11, 1, 1, 0); chk(dq_oe_o, 0, "R8");

    // R10: short counter refresh stays, long one becomes self refresh
    cyc(1, 2'b00, 1, 1, 0); repeat (31) cyc(0, 2'b00, 1, 1, 0);
    cyc(1, 2'b00, 1, 1, 0); chk(cls_o, 6, "R10");
    repeat (40) cyc(0, 2'b00, 1, 1, 0);
    cyc(1, 2'b00, 1, 1, 0); chk(cls_o, 8, "R10"); cyc(1, 2'b11, 1, 1, 0);

    // R11: second lane falls with WE disagreeing
    cyc(1, 2'b11, 0, 1, 0); cyc(0, 2'b11, 0, 1, 46); cyc(0, 2'b10, 0, 1, 8); chk(wr_o, 1, "R11");
    cyc(0, 2'b00, 1, 1, 0); chk(err_o, 1, "R11"); chk(wr_o, 0, "R11");
    cyc(1, 2'b11, 1, 1, 0);

    // R6: page mode, class kept from first column cycle
    cyc(0, 2'b11, 1, 1, 47); cyc(0, 2'b00, 1, 0, 1); cyc(0, 2'b11, 1, 0, 0);
    cyc(0, 2'b11, 0, 1, 0); cyc(0, 2'b00, 0, 1, 2); chk(wr_o, 3, "R6"); chk(col_o, 2, "R6");
    cyc(1, 2'b11, 1, 1, 0); chk(cls_o, 1, "R6");

    // R9: counter wrap
    while (m_cnt != 4095) begin cyc(1, 2'b00, 1, 1, 0); cyc(0, 2'b00, 1, 1, 0); end
    cyc(1, 2'b00, 1, 1, 0); cyc(0, 2'b00, 1, 1, 0); chk(row_o, 4095, "R9");
    cyc(1, 2'b00, 1, 1, 0); cyc(0, 2'b00, 1, 1, 0); chk(row_o, 0, "R9");
    cyc(1, 2'b11, 1, 1, 0); cyc(1, 2'b11, 1, 1, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule